// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block sits on the read path of a NOR flash device. While an embedded program or erase operation runs, reads of the array return a status word instead of stored data. Two toggle bits in that word carry different information. The mode toggle is bit 6, and it shows whether an operation is running. The sector toggle is bit 2, and it shows whether the read address lies in a sector marked for erasure. Read together, the two bits let a host tell apart the device mode and the state of each sector.

The operation mode, the per-sector erase mask, the array data and a timeout indication come from outside the block. The block does not model the embedded algorithms, the command decoder or the storage. A pulse on `wr_final` marks the rising edge of the last write-enable pulse of a command sequence. Status reporting starts only after that pulse. Each toggle bit is a flip-flop that inverts once per read strobe that returns status. It does not change on every clock.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset `rd_data` is 0, `tmo_flag` is 0 and both toggle bits start at 0.
- R2: When `mode` is 0 (idle), or is any unused code from 5 to 7, a read returns `array_data`. The result appears on `rd_data` one cycle after the strobe.
- R3: Status is reported only once a `wr_final` pulse has been seen while `mode` is not idle. Reads before that pulse return `array_data`. Returning to idle clears this condition.
- R4: In mode 1 (program), bit 6 inverts on each successive status read and bit 2 stays constant.
- R5: In mode 2 (erasing), a read in a sector whose `sel_mask` bit is set returns a word in which both bit 6 and bit 2 invert on each successive read.
- R6: In mode 2, a read in an unselected sector returns a word in which bit 6 inverts and bit 2 stays constant.
- R7: In mode 3 (erase suspended), a read in a selected sector returns a word in which bit 2 inverts and bit 6 stays constant.
- R8: In mode 3, a read in an unselected sector returns `array_data`.
- R9: In mode 4 (program during suspend), bit 6 inverts on reads at any address.
- R10: Bit 5 of a status word, and the `tmo_flag` output, are 1 only when `timeout` is high during a reported operation. Otherwise they are 0.
- R11: In a status word, every bit other than 6, 5 and 2 is 0. The sector index is `rd_addr[AW-1:SECT_BITS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operation mode code (0 idle, 1 program, 2 erase, 3 suspend, 4 program in suspend) |
| sel_mask | input | NSECT | Sectors selected for erasure |
| wr_final | input | 1 | Pulse for the final write-enable rising edge of a command |
| timeout | input | 1 | Operation exceeded its time limit |
| rd_strobe | input | 1 | One-cycle read request |
| rd_addr | input | AW | Word address of the read |
| array_data | input | DW | Stored data at rd_addr |
| rd_data | output | DW | Read result, registered |
| tmo_flag | output | 1 | Timeout during a reported operation |

## Verification
The hardest case to reach is a suspended erase in which reads alternate between selected and unselected sectors. The sector toggle must keep its phase across the array-data reads in between, while the mode toggle must not move at all. The bench enters suspend only after several erase-phase reads have moved both toggles. It then compares consecutive status reads at a selected address with a read at an unselected address placed between them.

// File: rtl/flash_toggle_status.sv
module flash_toggle_status #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int NSECT = 8,
  parameter int SECT_BITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode,
  input  logic [NSECT-1:0] sel_mask,
  input  logic             wr_final,
  input  logic             timeout,
  input  logic             rd_strobe,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    array_data,
  output logic [DW-1:0]    rd_data,
  output logic             tmo_flag
);
  localparam int IW = AW - SECT_BITS;

  logic          armed, t6, t2;
  logic [IW-1:0] sidx;
  logic          in_sel, busy, show_stat, flip6, flip2;
  logic [DW-1:0] stat_word;

  assign sidx   = rd_addr[AW-1:SECT_BITS];
  assign in_sel = (32'(sidx) < NSECT) ? sel_mask[sidx] : 1'b0;
  assign busy   = (mode >= 3'd1) && (mode <= 3'd4);
  assign tmo_flag = armed && busy && timeout;

  always_comb begin
    show_stat = armed && busy;
    flip6 = 1'b0;
    flip2 = 1'b0;
    case (mode)
      3'd1: flip6 = 1'b1;
      3'd2: begin flip6 = 1'b1; flip2 = in_sel; end
      3'd3: begin flip2 = in_sel; show_stat = armed && in_sel; end
      3'd4: flip6 = 1'b1;
      default: ;
    endcase
    stat_word = '0;
    stat_word[6] = t6;
    stat_word[5] = tmo_flag;
    stat_word[2] = t2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      t6      <= 1'b0;
      t2      <= 1'b0;
      rd_data <= '0;
    end else begin
      if (!busy) armed <= 1'b0;
      else if (wr_final) armed <= 1'b1;
      if (rd_strobe) begin
        rd_data <= show_stat ? stat_word : array_data;
        if (show_stat) begin
          t6 <= t6 ^ flip6;
          t2 <= t2 ^ flip2;
        end
      end
    end
  end
endmodule

module flash_toggle_status_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          rd_strobe,
  input logic          armed,
  input logic          in_sel,
  input logic          t6,
  input logic          t2,
  input logic [DW-1:0] array_data,
  input logic [DW-1:0] rd_data,
  input logic          tmo_flag
);
  a_r2_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && (mode == 3'd0)) |=> (rd_data == $past(array_data)));
  a_r3_unarmed_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !armed) |=> (rd_data == $past(array_data)));
  a_r5_erase_mode_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && armed && mode == 3'd2) |=> (t6 != $past(t6)));
  a_r7_susp_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && mode == 3'd3) |=> (t6 == $past(t6)));
  a_r6_unsel_sector_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && mode == 3'd2 && !in_sel) |=> (t2 == $past(t2)));
  a_r10_tmo_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> (armed && mode != 3'd0));
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && armed && (mode == 3'd1 || mode == 3'd2 || mode == 3'd4))
      |=> ((rd_data & 16'hFF9B) == 16'h0));
endmodule

bind flash_toggle_status flash_toggle_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_strobe(rd_strobe),
  .armed(armed), .in_sel(in_sel), .t6(t6), .t2(t2),
  .array_data(array_data), .rd_data(rd_data), .tmo_flag(tmo_flag)
);

// File: tb/tb_flash_toggle_status.sv
module tb_flash_toggle_status;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  mode = 0;
  logic [7:0]  sel_mask = 8'b0000_0010;
  logic        wr_final = 0, timeout = 0, rd_strobe = 0;
  logic [11:0] rd_addr = 0;
  logic [15:0] array_data = 16'hA5C3;
  logic [15:0] rd_data;
  logic        tmo_flag;
  int tests = 0, fails = 0;
  localparam logic [11:0] SEL = 12'h210, UNSEL = 12'h410;

  always #4 clk = ~clk;

  flash_toggle_status dut (.clk(clk), .rst_n(rst_n), .mode(mode), .sel_mask(sel_mask),
    .wr_final(wr_final), .timeout(timeout), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .array_data(array_data), .rd_data(rd_data), .tmo_flag(tmo_flag));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a; rd_strobe = 1;
    @(negedge clk); rd_strobe = 0; d = rd_data;
  endtask

  task automatic start(input logic [2:0] m);
    @(negedge clk); mode = m; wr_final = 1;
    @(negedge clk); wr_final = 0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 16'h0);
    chk("R1 tmo_flag", {15'b0, tmo_flag}, 16'h0);
  endtask

  task automatic t_idle;
    logic [15:0] d;
    mode = 0; rd(SEL, d); chk("R2 idle", d, 16'hA5C3);
    mode = 6; rd(SEL, d); chk("R2 unused code", d, 16'hA5C3);
    mode = 0;
  endtask

  task automatic t_prog;
    logic [15:0] a, b;
    @(negedge clk); mode = 1;
    rd(SEL, a); chk("R3 before wr_final", a, 16'hA5C3);
    start(1);
    rd(SEL, a); rd(SEL, b);
    chk("R4 bit6 toggles", {15'b0, a[6] ^ b[6]}, 16'h1);
    chk("R4 bit2 steady", {15'b0, a[2] ^ b[2]}, 16'h0);
    chk("R11 unused zero", b & 16'hFF9B, 16'h0);
    @(negedge clk); mode = 0;
    rd(SEL, a); chk("R3 idle clears", a, 16'hA5C3);
    @(negedge clk); mode = 1;
    rd(SEL, a); chk("R3 rearm needed", a, 16'hA5C3);
    @(negedge clk); mode = 0;
  endtask

  task automatic t_erase_susp;
    logic [15:0] a, b, c;
    start(2);
    rd(SEL, a); rd(SEL, b);
    chk("R5 bit6", {15'b0, a[6] ^ b[6]}, 16'h1);
    chk("R5 bit2", {15'b0, a[2] ^ b[2]}, 16'h1);
    rd(UNSEL, a); rd(UNSEL, b);
    chk("R6 bit6", {15'b0, a[6] ^ b[6]}, 16'h1);
    chk("R6 bit2", {15'b0, a[2] ^ b[2]}, 16'h0);
    @(negedge clk); mode = 3;
    rd(SEL, a); rd(UNSEL, c); rd(SEL, b);
    chk("R8 unsel data", c, 16'hA5C3);
    chk("R7 bit2", {15'b0, a[2] ^ b[2]}, 16'h1);
    chk("R7 bit6", {15'b0, a[6] ^ b[6]}, 16'h0);
    @(negedge clk); mode = 4;
    rd(UNSEL, a); rd(SEL, b);
    chk("R9 bit6", {15'b0, a[6] ^ b[6]}, 16'h1);
    chk("R11 unused zero", b & 16'hFF9B, 16'h0);
  endtask

  task automatic t_timeout;
    logic [15:0] a;
    @(negedge clk); timeout = 1; #1;
    chk("R10 flag on", {15'b0, tmo_flag}, 16'h1);
    rd(UNSEL, a); chk("R10 bit5", {15'b0, a[5]}, 16'h1);
    @(negedge clk); timeout = 0; #1;
    chk("R10 flag off", {15'b0, tmo_flag}, 16'h0);
    rd(UNSEL, a); chk("R10 bit5 low", {15'b0, a[5]}, 16'h0);
    @(negedge clk); mode = 0; timeout = 1; #1;
    chk("R10 idle flag", {15'b0, tmo_flag}, 16'h0);
    timeout = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset; t_idle; t_prog; t_erase_susp; t_timeout;
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule